// File: doc/BRIEF.md
# Manchester/NRZ Serial Transmit Modulator

This block turns the contents of two byte FIFOs into one serial line. A telegram has up to four parts, always in this order. First come the bytes of a symbol FIFO, sent as raw levels. Next comes the payload held in a data FIFO, sent Manchester-coded or as plain NRZ. A CRC of 4, 8 or 16 bits, computed over that payload, may follow. A programmable stop pattern may close the telegram. Each part is skipped when it is empty or disabled.

Every output level lasts one period of an external clock-enable, `tick`. In Manchester mode that enable runs at the half-bit rate, so one payload bit spans two ticks. Symbol bits, NRZ bits and stop bits each take one tick. The output can be inverted, and the bit order of data-FIFO bytes can be chosen. All configuration is captured when a telegram starts, so later changes to the configuration inputs do not disturb a telegram in flight.

The FIFOs are read first-word-fall-through: the head entry is visible whenever the empty flag is low, and a one-cycle pop strobe removes it.

Top module: `sermod_tx`

## Requirements
- R1: A `start` pulse while `busy` is low captures every `cfg_*` input and raises `busy` on the next cycle. A `start` pulse while `busy` is high is ignored. Changes to `cfg_*` while `busy` is high do not affect the running telegram.
- R2: While `busy` is high, each `tick` cycle drives exactly one new level onto `tx_out`, and `tx_out` holds between ticks. The telegram is sent in this order: symbol bytes, then data payload, then CRC (if enabled), then stop pattern (if enabled). On the first tick after the last level, `busy` falls.
- R3: Symbol-FIFO bytes are sent MSB-first (bit 7 first), one tick per bit, never Manchester-coded. Each bit goes out XOR `cfg_invert`.
- R4: Each data entry carries `dat_bits` valid bits, where 0 means all 8. With `cfg_msb_first`=1 the bits sent are bit 7 down to bit 8-n, in that order. With `cfg_msb_first`=0 the bits sent are bit 0 up to bit n-1, in that order.
- R5: With `cfg_nrz`=1, each payload bit b takes one tick with level b XOR `cfg_invert`.
- R6: With `cfg_nrz`=0, each payload bit b takes two ticks: first (NOT b) XOR `cfg_invert`, then b XOR `cfg_invert`. So with default polarity a 1 rises at mid-bit, and with inverted polarity a 1 falls at mid-bit.
- R7: The CRC width follows `cfg_crc_len`: 2'b00 gives 4 bits, 2'b01 gives 8, 2'b11 gives 16, and 2'b10 gives 4.
- R8: With `cfg_crc_en`=1, the CRC register of width w starts at `cfg_crc_init` masked to w bits. For each payload bit d, in transmit order, the update is: f = c[w-1]^d, then c = ((c<<1) ^ (f ? poly : 0)) masked to w bits. The result is sent MSB-first right after the payload, with the same NRZ or Manchester coding as the payload.
- R9: With `cfg_stop_en`=1 and length L = min(`cfg_stop_len`, 16), the bits `cfg_stop_pat[L-1]` down to `cfg_stop_pat[0]` are sent last, one tick each, XOR `cfg_invert`, never Manchester-coded. When the stop pattern is disabled, or L=0, nothing is sent.
- R10: After reset `tx_out` is 0 and `busy` is 0. While `busy` is low, `tx_out` rests at the `cfg_invert` value captured by the last accepted start.
- R11: Each FIFO entry is popped exactly once, in the tick cycle that sends its first bit. No pop happens from an empty FIFO or while idle. The data FIFO is read only once the symbol FIFO is empty.
- R12: A telegram with both FIFOs empty and no CRC and no stop pattern stays busy until the first tick and sends nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Output-level clock-enable (half-bit rate in Manchester mode) |
| start | input | 1 | Begin a telegram when idle |
| busy | output | 1 | Telegram in progress |
| sym_empty | input | 1 | Symbol FIFO empty |
| sym_data | input | BYTE_W | Symbol FIFO head entry |
| sym_pop | output | 1 | Pop strobe for symbol FIFO |
| dat_empty | input | 1 | Data FIFO empty |
| dat_data | input | BYTE_W | Data FIFO head entry |
| dat_bits | input | clog2(BYTE_W) | Valid bits in head entry, 0 = full byte |
| dat_pop | output | 1 | Pop strobe for data FIFO |
| cfg_msb_first | input | 1 | Data-FIFO bit order: 1 MSB-first, 0 LSB-first |
| cfg_stop_en | input | 1 | Append stop pattern |
| cfg_invert | input | 1 | Invert output polarity |
| cfg_nrz | input | 1 | 1 NRZ payload, 0 Manchester payload |
| cfg_crc_len | input | 2 | CRC width code |
| cfg_crc_en | input | 1 | Append CRC |
| cfg_crc_poly | input | 16 | CRC polynomial (low w bits used) |
| cfg_crc_init | input | 16 | CRC initial value (low w bits used) |
| cfg_stop_pat | input | STOP_W | Stop pattern |
| cfg_stop_len | input | clog2(STOP_W+1) | Stop pattern length in bits |
| tx_out | output | 1 | Serial output |

## Verification
The bench targets the places where one part of a telegram hands over to the next. Examples are a symbol FIFO that drains straight into a partial data byte, and a last Manchester half-bit followed by the first CRC bit. A design that wastes a tick or drops a level at those joins shifts the whole rest of the stream. The bench also runs the unused CRC length code, a stop length above the pattern width and a zero stop length. These would show up as a wrong-width checksum or a garbage stop bit. Finally it pulses `start` and flips the polarity and coding inputs in the middle of a telegram. A design that does not capture its configuration would change its coding halfway through, or come to rest at the wrong idle level.

// File: rtl/sermod_pkg.sv
package sermod_pkg;

  localparam int CRC_MAX = 16;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_SYM  = 3'd1,
    PH_DAT  = 3'd2,
    PH_CRC  = 3'd3,
    PH_STP  = 3'd4
  } phase_t;

  typedef struct packed {
    logic       msb;
    logic       stop_en;
    logic       inv;
    logic       nrz;
    logic [1:0] crc_len;
    logic       crc_en;
  } cfg_t;

  function automatic logic [4:0] crc_len_of(input logic [1:0] code);
    case (code)
      2'b01:   return 5'd8;
      2'b11:   return 5'd16;
      default: return 5'd4;
    endcase
  endfunction

  function automatic logic [CRC_MAX-1:0] crc_mask_of(input logic [1:0] code);
    case (code)
      2'b01:   return 16'h00FF;
      2'b11:   return 16'hFFFF;
      default: return 16'h000F;
    endcase
  endfunction

endpackage

// File: rtl/sermod_crc.sv
module sermod_crc
  import sermod_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [CRC_MAX-1:0] init,
  input  logic [CRC_MAX-1:0] poly,
  input  logic [1:0]         len_code,
  input  logic               step,
  input  logic               din,
  output logic [CRC_MAX-1:0] crc
);

  logic [CRC_MAX-1:0] crc_q;
  logic [CRC_MAX-1:0] mask;
  logic [CRC_MAX-1:0] top_sh;
  logic               fb;

  always_comb begin
    mask   = crc_mask_of(len_code);
    top_sh = crc_q >> (crc_len_of(len_code) - 5'd1);
    fb     = top_sh[0] ^ din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_q <= '0;
    end else if (load) begin
      crc_q <= init;
    end else if (step) begin
      crc_q <= ((crc_q << 1) ^ (fb ? poly : '0)) & mask;
    end
  end

  assign crc = crc_q;

  AST_CRC_MASKED: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> ((crc_q & ~mask) == '0)); // R8

endmodule

// File: rtl/sermod_seq.sv
module sermod_seq
  import sermod_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int STOP_W = 16,
  localparam int NBW   = $clog2(BYTE_W),
  localparam int CW    = $clog2(BYTE_W) + 1,
  localparam int SLW   = $clog2(STOP_W + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               start_acc,
  input  cfg_t               cfg,
  input  logic [STOP_W-1:0]  stop_pat,
  input  logic [SLW-1:0]     stop_len,
  input  logic [CRC_MAX-1:0] crc_val,
  input  logic               sym_empty,
  input  logic [BYTE_W-1:0]  sym_data,
  input  logic               dat_empty,
  input  logic [BYTE_W-1:0]  dat_data,
  input  logic [NBW-1:0]     dat_bits,
  output logic               sym_pop,
  output logic               dat_pop,
  output logic               busy,
  output logic               half_pend,
  output logic               emit,
  output logic               emit_lvl,
  output logic               finish,
  output logic               pay_step,
  output logic               pay_bit
);

  phase_t             phase, phase_n;
  logic [BYTE_W-1:0]  sh, sh_n;
  logic [CW-1:0]      cnt, cnt_n;
  logic               half_n, half_bit, hbit_n;
  logic [4:0]         crc_idx, cidx_n;
  logic [SLW-1:0]     stop_idx, sidx_n;

  // Bit-reversed copy of the data head for LSB-first order
  logic [BYTE_W-1:0]  rev;
  for (genvar g = 0; g < BYTE_W; g++) begin : g_rev
    assign rev[g] = dat_data[BYTE_W-1-g];
  end

  logic [BYTE_W-1:0]  aligned;
  logic [CW-1:0]      n_load;
  assign aligned = cfg.msb ? dat_data : rev;
  assign n_load  = (dat_bits == '0) ? CW'(BYTE_W) : {1'b0, dat_bits};

  phase_t             p;
  logic               done, bitv, man;
  logic [4:0]         cidx;
  logic [SLW-1:0]     sidx;
  logic [CRC_MAX-1:0] crc_sh;
  logic [STOP_W-1:0]  stop_sh;

  always_comb begin
    phase_n  = phase;
    sh_n     = sh;
    cnt_n    = cnt;
    half_n   = half_pend;
    hbit_n   = half_bit;
    cidx_n   = crc_idx;
    sidx_n   = stop_idx;
    sym_pop  = 1'b0;
    dat_pop  = 1'b0;
    emit     = 1'b0;
    emit_lvl = 1'b0;
    finish   = 1'b0;
    pay_step = 1'b0;
    p        = phase;
    done     = 1'b0;
    bitv     = 1'b0;
    man      = 1'b0;
    cidx     = '0;
    sidx     = '0;
    crc_sh   = '0;
    stop_sh  = '0;
    if (start_acc) begin
      phase_n = PH_SYM;
      cnt_n   = '0;
      half_n  = 1'b0;
    end else if (tick && phase != PH_IDLE) begin
      if (half_pend) begin
        emit     = 1'b1;
        emit_lvl = half_bit ^ cfg.inv;
        half_n   = 1'b0;
      end else begin
        // symbol bytes: raw, MSB-first
        if (p == PH_SYM) begin
          if (cnt != '0) begin
            bitv  = sh[BYTE_W-1];
            sh_n  = sh << 1;
            cnt_n = cnt - 1'b1;
            done  = 1'b1;
          end else if (!sym_empty) begin
            sym_pop = 1'b1;
            bitv    = sym_data[BYTE_W-1];
            sh_n    = sym_data << 1;
            cnt_n   = CW'(BYTE_W - 1);
            done    = 1'b1;
          end else begin
            p = PH_DAT;
          end
        end
        // payload: order per cfg, coded per cfg
        if (!done && p == PH_DAT) begin
          if (cnt != '0) begin
            bitv     = sh[BYTE_W-1];
            sh_n     = sh << 1;
            cnt_n    = cnt - 1'b1;
            done     = 1'b1;
            man      = !cfg.nrz;
            pay_step = 1'b1;
          end else if (!dat_empty) begin
            dat_pop  = 1'b1;
            bitv     = aligned[BYTE_W-1];
            sh_n     = aligned << 1;
            cnt_n    = n_load - 1'b1;
            done     = 1'b1;
            man      = !cfg.nrz;
            pay_step = 1'b1;
          end else begin
            p = cfg.crc_en ? PH_CRC : PH_STP;
          end
        end
        // checksum, MSB-first, coded like the payload
        if (!done && p == PH_CRC) begin
          cidx = (phase == PH_CRC) ? crc_idx : crc_len_of(cfg.crc_len);
          if (cidx != '0) begin
            crc_sh = crc_val >> (cidx - 5'd1);
            bitv   = crc_sh[0];
            cidx_n = cidx - 5'd1;
            done   = 1'b1;
            man    = !cfg.nrz;
          end else begin
            p = PH_STP;
          end
        end
        // stop pattern: raw, MSB-first
        if (!done && p == PH_STP) begin
          sidx = (phase == PH_STP) ? stop_idx : (cfg.stop_en ? stop_len : '0);
          if (sidx != '0) begin
            stop_sh = stop_pat >> (sidx - 1'b1);
            bitv    = stop_sh[0];
            sidx_n  = sidx - 1'b1;
            done    = 1'b1;
          end
        end
        if (done) begin
          emit    = 1'b1;
          phase_n = p;
          if (man) begin
            emit_lvl = ~bitv ^ cfg.inv;
            half_n   = 1'b1;
            hbit_n   = bitv;
          end else begin
            emit_lvl = bitv ^ cfg.inv;
          end
        end else begin
          finish  = 1'b1;
          phase_n = PH_IDLE;
        end
      end
    end
  end

  assign pay_bit = bitv;
  assign busy    = (phase != PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      sh        <= '0;
      cnt       <= '0;
      half_pend <= 1'b0;
      half_bit  <= 1'b0;
      crc_idx   <= '0;
      stop_idx  <= '0;
    end else begin
      phase     <= phase_n;
      sh        <= sh_n;
      cnt       <= cnt_n;
      half_pend <= half_n;
      half_bit  <= hbit_n;
      crc_idx   <= cidx_n;
      stop_idx  <= sidx_n;
    end
  end

  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    (sym_pop |-> !sym_empty) and (dat_pop |-> !dat_empty)); // R11

  AST_NO_POP_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!sym_pop && !dat_pop)); // R11

  AST_DAT_AFTER_SYM: assert property (@(posedge clk) disable iff (rst)
    dat_pop |-> sym_empty); // R11

  AST_HALF_ONCE: assert property (@(posedge clk) disable iff (rst)
    (tick && half_pend && busy) |=> !half_pend); // R6

endmodule

// File: rtl/sermod_line.sv
module sermod_line (
  input  logic clk,
  input  logic rst,
  input  logic start_acc,
  input  logic start_inv,
  input  logic emit,
  input  logic lvl,
  input  logic finish,
  input  logic idle_inv,
  output logic tx_out
);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_out <= 1'b0;
    end else if (start_acc) begin
      tx_out <= start_inv;
    end else if (emit) begin
      tx_out <= lvl;
    end else if (finish) begin
      tx_out <= idle_inv;
    end
  end

endmodule

// File: rtl/sermod_tx.sv
module sermod_tx
  import sermod_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int STOP_W = 16,
  localparam int NBW   = $clog2(BYTE_W),
  localparam int SLW   = $clog2(STOP_W + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               start,
  output logic               busy,
  input  logic               sym_empty,
  input  logic [BYTE_W-1:0]  sym_data,
  output logic               sym_pop,
  input  logic               dat_empty,
  input  logic [BYTE_W-1:0]  dat_data,
  input  logic [NBW-1:0]     dat_bits,
  output logic               dat_pop,
  input  logic               cfg_msb_first,
  input  logic               cfg_stop_en,
  input  logic               cfg_invert,
  input  logic               cfg_nrz,
  input  logic [1:0]         cfg_crc_len,
  input  logic               cfg_crc_en,
  input  logic [CRC_MAX-1:0] cfg_crc_poly,
  input  logic [CRC_MAX-1:0] cfg_crc_init,
  input  logic [STOP_W-1:0]  cfg_stop_pat,
  input  logic [SLW-1:0]     cfg_stop_len,
  output logic               tx_out
);

  cfg_t               cfg_q;
  logic [CRC_MAX-1:0] poly_q;
  logic [STOP_W-1:0]  pat_q;
  logic [SLW-1:0]     slen_q;
  logic               start_acc;
  logic               half_pend, emit, emit_lvl, finish, pay_step, pay_bit;
  logic [CRC_MAX-1:0] crc_val;

  assign start_acc = start && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      poly_q <= '0;
      pat_q  <= '0;
      slen_q <= '0;
    end else if (start_acc) begin
      cfg_q  <= '{msb: cfg_msb_first, stop_en: cfg_stop_en, inv: cfg_invert,
                  nrz: cfg_nrz, crc_len: cfg_crc_len, crc_en: cfg_crc_en};
      poly_q <= cfg_crc_poly;
      pat_q  <= cfg_stop_pat;
      slen_q <= (cfg_stop_len > SLW'(STOP_W)) ? SLW'(STOP_W) : cfg_stop_len;
    end
  end

  sermod_seq #(.BYTE_W(BYTE_W), .STOP_W(STOP_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .start_acc (start_acc),
    .cfg       (cfg_q),
    .stop_pat  (pat_q),
    .stop_len  (slen_q),
    .crc_val   (crc_val),
    .sym_empty (sym_empty),
    .sym_data  (sym_data),
    .dat_empty (dat_empty),
    .dat_data  (dat_data),
    .dat_bits  (dat_bits),
    .sym_pop   (sym_pop),
    .dat_pop   (dat_pop),
    .busy      (busy),
    .half_pend (half_pend),
    .emit      (emit),
    .emit_lvl  (emit_lvl),
    .finish    (finish),
    .pay_step  (pay_step),
    .pay_bit   (pay_bit)
  );

  sermod_crc u_crc (
    .clk      (clk),
    .rst      (rst),
    .load     (start_acc),
    .init     (cfg_crc_init),
    .poly     (poly_q),
    .len_code (cfg_q.crc_len),
    .step     (pay_step),
    .din      (pay_bit),
    .crc      (crc_val)
  );

  sermod_line u_line (
    .clk       (clk),
    .rst       (rst),
    .start_acc (start_acc),
    .start_inv (cfg_invert),
    .emit      (emit),
    .lvl       (emit_lvl),
    .finish    (finish),
    .idle_inv  (cfg_q.inv),
    .tx_out    (tx_out)
  );

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (tx_out == cfg_q.inv)); // R10

  AST_CFG_LOCK: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(cfg_q) && $stable(poly_q) && $stable(pat_q))); // R1

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    (busy && !tick) |=> $stable(tx_out)); // R2

  AST_MID_BIT_EDGE: assert property (@(posedge clk) disable iff (rst)
    (busy && tick && half_pend) |=> (tx_out != $past(tx_out))); // R6

endmodule

// File: tb/sermod_tx_test.sv
`timescale 1ns/1ps
module sermod_tx_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0, start = 1'b0;
  logic        busy, sym_pop, dat_pop, tx_out;
  logic        sym_empty = 1'b1, dat_empty = 1'b1;
  logic [7:0]  sym_data = 8'h00, dat_data = 8'h00;
  logic [2:0]  dat_bits = 3'd0;
  logic        cfg_msb_first = 1'b0, cfg_stop_en = 1'b0, cfg_invert = 1'b0, cfg_nrz = 1'b0;
  logic [1:0]  cfg_crc_len = 2'b00;
  logic        cfg_crc_en = 1'b0;
  logic [15:0] cfg_crc_poly = 16'h0, cfg_crc_init = 16'h0, cfg_stop_pat = 16'h0;
  logic [4:0]  cfg_stop_len = 5'd0;

  always #4 clk = ~clk;

  sermod_tx uut (
    .clk(clk), .rst(rst), .tick(tick), .start(start), .busy(busy),
    .sym_empty(sym_empty), .sym_data(sym_data), .sym_pop(sym_pop),
    .dat_empty(dat_empty), .dat_data(dat_data), .dat_bits(dat_bits), .dat_pop(dat_pop),
    .cfg_msb_first(cfg_msb_first), .cfg_stop_en(cfg_stop_en), .cfg_invert(cfg_invert),
    .cfg_nrz(cfg_nrz), .cfg_crc_len(cfg_crc_len), .cfg_crc_en(cfg_crc_en),
    .cfg_crc_poly(cfg_crc_poly), .cfg_crc_init(cfg_crc_init),
    .cfg_stop_pat(cfg_stop_pat), .cfg_stop_len(cfg_stop_len), .tx_out(tx_out)
  );

  int    checks = 0, errors = 0, cyc = 0, tdiv = 1, tcnt = 0;
  string cur_req = "R10";
  logic [7:0] sym_q[$];
  logic [7:0] dat_q[$];
  logic [2:0] nb_q[$];
  logic       exp_q[$];
  logic       m_busy = 1'b0, m_out = 1'b0, m_inv = 1'b0;
  logic       sp_s = 1'b0, dp_s = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic refresh();
    sym_empty = (sym_q.size() == 0);
    sym_data  = sym_empty ? 8'h00 : sym_q[0];
    dat_empty = (dat_q.size() == 0);
    dat_data  = dat_empty ? 8'h00 : dat_q[0];
    dat_bits  = dat_empty ? 3'd0 : nb_q[0];
  endtask

  task automatic put_sym(input logic [7:0] b);
    sym_q.push_back(b);
    refresh();
  endtask

  task automatic put_dat(input logic [7:0] b, input logic [2:0] nb);
    dat_q.push_back(b);
    nb_q.push_back(nb);
    refresh();
  endtask

  task automatic push_pay(input logic b, input logic inv, input logic nrz);
    if (nrz) exp_q.push_back(b ^ inv);
    else begin
      exp_q.push_back(~b ^ inv);
      exp_q.push_back(b ^ inv);
    end
  endtask

  // Expected level stream, written from the requirements
  task automatic build();
    int w, n, len;
    logic [15:0] c, mask;
    logic d, f;
    exp_q = {};
    foreach (sym_q[i])
      for (int k = 7; k >= 0; k--) exp_q.push_back(sym_q[i][k] ^ cfg_invert);
    w = (cfg_crc_len == 2'b01) ? 8 : (cfg_crc_len == 2'b11) ? 16 : 4;
    mask = 16'((32'd1 << w) - 1);
    c = cfg_crc_init & mask;
    foreach (dat_q[i]) begin
      n = (nb_q[i] == 3'd0) ? 8 : int'(nb_q[i]);
      for (int j = 0; j < n; j++) begin
        d = cfg_msb_first ? dat_q[i][7-j] : dat_q[i][j];
        f = c[w-1] ^ d;
        c = ((c << 1) ^ (f ? cfg_crc_poly : 16'h0)) & mask;
        push_pay(d, cfg_invert, cfg_nrz);
      end
    end
    if (cfg_crc_en)
      for (int k = w - 1; k >= 0; k--) push_pay(c[k], cfg_invert, cfg_nrz);
    if (cfg_stop_en) begin
      len = (cfg_stop_len > 5'd16) ? 16 : int'(cfg_stop_len);
      for (int k = len - 1; k >= 0; k--) exp_q.push_back(cfg_stop_pat[k] ^ cfg_invert);
    end
  endtask

  // Reference model, advanced on each rising edge
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_busy = 1'b0; m_out = 1'b0; m_inv = 1'b0;
    end else if (start && !m_busy) begin
      m_busy = 1'b1; m_inv = cfg_invert; m_out = cfg_invert;
      build();
    end else if (m_busy && tick) begin
      if (exp_q.size() > 0) m_out = exp_q.pop_front();
      else begin m_busy = 1'b0; m_out = m_inv; end
    end
    if (cyc == 190000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<190000 cycles", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(posedge clk) begin
    sp_s <= sym_pop;
    dp_s <= dat_pop;
  end

  // Compare, FIFO pops and tick drive, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk({cur_req, " busy"}, 32'(busy), 32'(m_busy));
      chk({cur_req, " tx_out"}, 32'(tx_out), 32'(m_out));
    end
    if (sp_s) begin
      if (sym_q.size() == 0) chk("R11 pop of empty symbol FIFO", 1, 0);
      else void'(sym_q.pop_front());
    end
    if (dp_s) begin
      if (dat_q.size() == 0) chk("R11 pop of empty data FIFO", 1, 0);
      else begin void'(dat_q.pop_front()); void'(nb_q.pop_front()); end
    end
    refresh();
    tick = (tcnt == 0);
    tcnt = (tcnt + 1 >= tdiv) ? 0 : tcnt + 1;
  end

  task automatic set_cfg(input logic msb, input logic inv, input logic nrz,
                         input logic crc_en, input logic [1:0] clen,
                         input logic [15:0] poly, input logic [15:0] init,
                         input logic stop_en, input logic [15:0] pat, input logic [4:0] slen);
    cfg_msb_first = msb; cfg_invert = inv; cfg_nrz = nrz;
    cfg_crc_en = crc_en; cfg_crc_len = clen; cfg_crc_poly = poly; cfg_crc_init = init;
    cfg_stop_en = stop_en; cfg_stop_pat = pat; cfg_stop_len = slen;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (m_busy && guard < 20000) begin @(negedge clk); guard++; end
    if (guard >= 20000) chk({cur_req, " watchdog"}, 1, 0);
    repeat (3) @(negedge clk);
    chk("R11 symbol FIFO drained", 32'(sym_q.size()), 0);
    chk("R11 data FIFO drained", 32'(dat_q.size()), 0);
  endtask

  task automatic run(input string tag);
    cur_req = tag;
    pulse_start();
    wait_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 reset tx_out", 32'(tx_out), 0);
    chk("R10 reset busy", 32'(busy), 0);

    // R3: symbol bytes only
    tdiv = 1;
    set_cfg(0, 0, 0, 0, 2'b00, 16'h0, 16'h0, 0, 16'h0, 5'd0);
    put_sym(8'hA5); put_sym(8'h3C);
    run("R3 symbol MSB-first");

    // R5/R4: NRZ, LSB-first, partial tail byte
    tdiv = 3;
    set_cfg(0, 0, 1, 0, 2'b00, 16'h0, 16'h0, 0, 16'h0, 5'd0);
    put_dat(8'h96, 3'd0); put_dat(8'h05, 3'd3);
    run("R5 R4 NRZ LSB-first");

    // R4/R6: Manchester, MSB-first, partial tail byte
    tdiv = 2;
    set_cfg(1, 0, 0, 0, 2'b00, 16'h0, 16'h0, 0, 16'h0, 5'd0);
    put_dat(8'hC3, 3'd0); put_dat(8'hA0, 3'd3);
    run("R4 R6 Manchester MSB-first");

    // R6/R3/R10: inverted Manchester after a symbol byte
    tdiv = 1;
    set_cfg(0, 1, 0, 0, 2'b00, 16'h0, 16'h0, 0, 16'h0, 5'd0);
    put_sym(8'hF0); put_dat(8'h5A, 3'd0);
    run("R6 R3 inverted");
    chk("R10 idle level inverted", 32'(tx_out), 1);

    // R7/R8: each CRC length code
    set_cfg(1, 0, 0, 1, 2'b00, 16'h0003, 16'h000F, 0, 16'h0, 5'd0);
    put_dat(8'hD2, 3'd0);
    run("R7 R8 CRC4 Manchester");
    set_cfg(1, 0, 1, 1, 2'b01, 16'h0007, 16'h0000, 0, 16'h0, 5'd0);
    put_dat(8'h31, 3'd0); put_dat(8'h0B, 3'd4);
    run("R7 R8 CRC8 NRZ");
    tdiv = 2;
    set_cfg(1, 1, 1, 1, 2'b11, 16'h1021, 16'hFFFF, 0, 16'h0, 5'd0);
    put_dat(8'h12, 3'd0); put_dat(8'h34, 3'd0);
    run("R7 R8 CRC16 inverted");
    tdiv = 1;
    set_cfg(0, 0, 0, 1, 2'b10, 16'h0003, 16'h0005, 0, 16'h0, 5'd0);
    put_dat(8'h6E, 3'd0);
    run("R7 unused length code");

    // R9: stop pattern, zero length, and length above the pattern width
    set_cfg(0, 1, 0, 0, 2'b00, 16'h0, 16'h0, 1, 16'h002D, 5'd6);
    put_sym(8'h81);
    run("R9 stop pattern inverted");
    set_cfg(0, 0, 1, 0, 2'b00, 16'h0, 16'h0, 1, 16'hFFFF, 5'd0);
    put_dat(8'h0F, 3'd0);
    run("R9 stop length zero");
    set_cfg(0, 0, 1, 0, 2'b00, 16'h0, 16'h0, 1, 16'hB3C5, 5'd20);
    run("R9 stop length clamp");

    // R12: empty telegram, slow tick
    tdiv = 5;
    set_cfg(0, 0, 0, 0, 2'b00, 16'h0, 16'h0, 0, 16'h0, 5'd0);
    cur_req = "R12 empty telegram";
    pulse_start();
    chk("R12 busy after start", 32'(busy), 1);
    wait_idle();

    // R1: start while busy and configuration changes mid-telegram
    tdiv = 2;
    set_cfg(1, 0, 0, 1, 2'b01, 16'h0007, 16'h00AA, 1, 16'h0005, 5'd3);
    put_sym(8'h69); put_dat(8'hE7, 3'd0); put_dat(8'h01, 3'd1);
    cur_req = "R1 config capture";
    pulse_start();
    repeat (6) @(negedge clk);
    start = 1'b1; cfg_invert = 1'b1; cfg_nrz = 1'b1; cfg_msb_first = 1'b0;
    cfg_stop_len = 5'd9; cfg_crc_poly = 16'h00FF;
    @(negedge clk); start = 1'b0;
    wait_idle();
    chk("R1 idle level keeps captured polarity", 32'(tx_out), 0);

    // R2: full telegram, every part present, inverted, slow tick
    tdiv = 4;
    set_cfg(0, 1, 0, 1, 2'b11, 16'h8005, 16'h1234, 1, 16'h0A5A, 5'd12);
    put_sym(8'h55); put_sym(8'hC7); put_dat(8'hF1, 3'd0); put_dat(8'h3E, 3'd6);
    run("R2 full telegram order");
    chk("R10 idle after full telegram", 32'(tx_out), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule